// File: doc/BRIEF.md
# Monotonic Capability Derivation Unit

This block derives a new capability from an existing one without ever granting more authority than the source held. A capability carries a validity tag, a sealed flag with an object type, a permission mask, and a region described by base, length and a base-relative offset. An opcode selects one of five derivations: write the offset, add to the offset, shrink the region to a sub-range that starts at the current offset, clear permissions with an AND mask, or seal the capability under an object type.

Each request enters on a valid/ready input stream together with an operand. The result leaves on a valid/ready output stream one clock after acceptance. It comes with a fault cause that reports which rule was broken. The output stage holds a single result. `in_ready` is high whenever the stage is empty or its result is being taken in the same cycle, so back-pressure on `out_ready` stalls the input at once. A result that is not yet taken stays on the outputs unchanged.

Top module: `cap_derive_unit`

## Requirements
- R1: Opcode 0 (write offset) makes the result offset equal to the operand and keeps the tag and every other field, even when the new offset lies outside the region.
- R2: Opcode 1 (add offset) makes the result offset the source offset plus the operand, modulo 2^AW, and keeps the tag and every other field.
- R3: Opcode 2 (narrow region) succeeds only when offset + operand <= length, evaluated without wrap. On success, the new base is base + offset, the new length is the operand and the new offset is zero. Otherwise the cause is 3 (bounds).
- R4: Opcode 3 (mask permissions) makes the result permissions the source permissions ANDed with the low PW bits of the operand.
- R5: Opcode 4 (seal) sets the sealed flag and stores the low OTW bits of the operand as the object type. All other fields are kept.
- R6: A legal opcode applied to a sealed source, including a second seal, faults with cause 2 (sealed).
- R7: A legal opcode applied to an untagged source faults with cause 1 (tag), and the result is untagged. This cause takes precedence over cause 2.
- R8: Opcodes 5, 6 and 7 fault with cause 4 (illegal). This cause takes precedence over every other cause.
- R9: On any fault, the result carries the source fields unchanged with the tag cleared. A successful result has cause 0 and keeps the tag set.
- R10: The result appears one cycle after acceptance. It stays stable while `out_ready` is low, and `in_ready` equals `!out_valid || out_ready`.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted this cycle when valid |
| in_op | input | 3 | Derivation opcode |
| in_opnd | input | AW | Operand value |
| in_tag | input | 1 | Source validity tag |
| in_sealed | input | 1 | Source sealed flag |
| in_otype | input | OTW | Source object type |
| in_perms | input | PW | Source permissions |
| in_base | input | AW | Source region base |
| in_len | input | AW | Source region length |
| in_off | input | AW | Source offset |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_tag | output | 1 | Result tag |
| out_sealed | output | 1 | Result sealed flag |
| out_otype | output | OTW | Result object type |
| out_perms | output | PW | Result permissions |
| out_base | output | AW | Result base |
| out_len | output | AW | Result length |
| out_off | output | AW | Result offset |
| out_cause | output | 3 | Fault cause: 0 none, 1 tag, 2 sealed, 3 bounds, 4 illegal |

## Verification
The bench builds the unit with AW = 32, PW = 8 and OTW = 24. With a 32-bit address, an offset that wraps past 2^32 can be written as a literal. The operand is still wide enough to carry an object type with spare upper bits, and the bench checks that those bits are dropped. With eight permission bits, the full-mask, zero-mask and partial-mask cases can be written out exactly. The region-narrowing cases in the bench are exact fit, one past the fit and an offset already beyond the length. The bench also stalls the output side in a repeating pattern, so that results are held across back-pressure.

// File: rtl/cap_derive_pkg.sv
package cap_derive_pkg;
  typedef enum logic [2:0] {
    OP_SET_OFF  = 3'd0,
    OP_ADD_OFF  = 3'd1,
    OP_NARROW   = 3'd2,
    OP_MASK     = 3'd3,
    OP_SEAL     = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    CZ_NONE    = 3'd0,
    CZ_TAG     = 3'd1,
    CZ_SEALED  = 3'd2,
    CZ_BOUNDS  = 3'd3,
    CZ_ILLEGAL = 3'd4
  } cause_e;

  localparam logic [2:0] OP_LAST_LEGAL = 3'd4;
endpackage

// File: rtl/cap_offset_path.sv
module cap_offset_path #(
  parameter int AW = 64
) (
  input  logic [2:0]    op,
  input  logic [AW-1:0] off,
  input  logic [AW-1:0] opnd,
  output logic [AW-1:0] new_off
);
  import cap_derive_pkg::*;

  always_comb begin
    if (op == OP_ADD_OFF) new_off = off + opnd;
    else                  new_off = opnd;
  end
endmodule

// File: rtl/cap_bounds_chk.sv
module cap_bounds_chk #(
  parameter int AW = 64
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] len,
  input  logic [AW-1:0] off,
  input  logic [AW-1:0] req_len,
  output logic          fits,
  output logic [AW-1:0] new_base
);
  localparam int EW = AW + 1;
  logic [EW-1:0] reach;

  always_comb begin
    reach    = {1'b0, off} + {1'b0, req_len};
    fits     = (reach <= {1'b0, len});
    new_base = base + off;
  end
endmodule

// File: rtl/cap_fault_sel.sv
module cap_fault_sel (
  input  logic [2:0] op,
  input  logic       tag,
  input  logic       sealed,
  input  logic       fits,
  output logic [2:0] cause
);
  import cap_derive_pkg::*;

  always_comb begin
    if (op > OP_LAST_LEGAL)              cause = CZ_ILLEGAL;
    else if (!tag)                       cause = CZ_TAG;
    else if (sealed)                     cause = CZ_SEALED;
    else if (op == OP_NARROW && !fits)   cause = CZ_BOUNDS;
    else                                 cause = CZ_NONE;
  end
endmodule

// File: rtl/cap_derive_unit.sv
module cap_derive_unit #(
  parameter int AW  = 64,
  parameter int PW  = 16,
  parameter int OTW = 24
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [2:0]     in_op,
  input  logic [AW-1:0]  in_opnd,
  input  logic           in_tag,
  input  logic           in_sealed,
  input  logic [OTW-1:0] in_otype,
  input  logic [PW-1:0]  in_perms,
  input  logic [AW-1:0]  in_base,
  input  logic [AW-1:0]  in_len,
  input  logic [AW-1:0]  in_off,
  output logic           out_valid,
  input  logic           out_ready,
  output logic           out_tag,
  output logic           out_sealed,
  output logic [OTW-1:0] out_otype,
  output logic [PW-1:0]  out_perms,
  output logic [AW-1:0]  out_base,
  output logic [AW-1:0]  out_len,
  output logic [AW-1:0]  out_off,
  output logic [2:0]     out_cause
);
  import cap_derive_pkg::*;

  localparam int EW = AW + 1;

  logic [AW-1:0]  n_off, n_base;
  logic           fits;
  logic [2:0]     cause;
  logic           r_tag, r_sealed;
  logic [OTW-1:0] r_otype;
  logic [PW-1:0]  r_perms;
  logic [AW-1:0]  r_base, r_len, r_off;
  logic           fire, acc_q;

  cap_offset_path #(.AW(AW)) u_off (
    .op(in_op), .off(in_off), .opnd(in_opnd), .new_off(n_off)
  );

  cap_bounds_chk #(.AW(AW)) u_bnd (
    .base(in_base), .len(in_len), .off(in_off), .req_len(in_opnd),
    .fits(fits), .new_base(n_base)
  );

  cap_fault_sel u_flt (
    .op(in_op), .tag(in_tag), .sealed(in_sealed), .fits(fits), .cause(cause)
  );

  always_comb begin
    r_tag    = in_tag;
    r_sealed = in_sealed;
    r_otype  = in_otype;
    r_perms  = in_perms;
    r_base   = in_base;
    r_len    = in_len;
    r_off    = in_off;
    if (cause != CZ_NONE) begin
      r_tag = 1'b0;
    end else begin
      case (in_op)
        OP_SET_OFF, OP_ADD_OFF: r_off = n_off;
        OP_NARROW: begin
          r_base = n_base;
          r_len  = in_opnd;
          r_off  = '0;
        end
        OP_MASK:  r_perms = in_perms & in_opnd[PW-1:0];
        OP_SEAL: begin
          r_sealed = 1'b1;
          r_otype  = in_opnd[OTW-1:0];
        end
        default: r_tag = 1'b0;
      endcase
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      acc_q     <= 1'b0;
      out_tag   <= 1'b0;
      out_cause <= CZ_NONE;
    end else begin
      acc_q <= fire;
      if (fire) begin
        out_valid  <= 1'b1;
        out_tag    <= r_tag;
        out_cause  <= cause;
      end else if (out_ready) begin
        out_valid  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fire) begin
      out_sealed <= r_sealed;
      out_otype  <= r_otype;
      out_perms  <= r_perms;
      out_base   <= r_base;
      out_len    <= r_len;
      out_off    <= r_off;
    end
  end

  AST_NO_WIDEN: assert property (@(posedge clk) disable iff (rst)
    acc_q && out_cause == CZ_NONE |->
      out_base >= $past(in_base) &&
      ({1'b0, out_base} + {1'b0, out_len}) <= (EW'($past(in_base)) + EW'($past(in_len)))); // R3
  AST_PERM_SUBSET: assert property (@(posedge clk) disable iff (rst)
    acc_q |-> (out_perms & ~$past(in_perms)) == '0); // R4
  AST_FAULT_UNTAG: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_cause != CZ_NONE |-> !out_tag); // R9
  AST_UNTAGGED_STAYS: assert property (@(posedge clk) disable iff (rst)
    acc_q && !$past(in_tag) |-> !out_tag && out_cause != CZ_NONE); // R7
  AST_SEALED_FROZEN: assert property (@(posedge clk) disable iff (rst)
    acc_q && $past(in_sealed) |-> out_cause != CZ_NONE); // R6
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_off) &&
      $stable(out_base) && $stable(out_cause) && $stable(out_tag)); // R10
endmodule

// File: tb/sim_cap_derive_unit.sv
`timescale 1ns/100ps
module sim_cap_derive_unit;
  localparam int AW = 32, PW = 8, OTW = 24;

  typedef struct packed {
    logic           tag;
    logic           sealed;
    logic [OTW-1:0] otype;
    logic [PW-1:0]  perms;
    logic [AW-1:0]  base;
    logic [AW-1:0]  len;
    logic [AW-1:0]  off;
    logic [2:0]     cause;
  } item_t;

  logic clk = 0, rst = 1;
  logic in_valid = 0, in_ready, out_valid, out_ready = 1;
  logic [2:0] in_op = 0;
  logic [AW-1:0] in_opnd = 0, in_base = 0, in_len = 0, in_off = 0;
  logic in_tag = 0, in_sealed = 0;
  logic [OTW-1:0] in_otype = 0;
  logic [PW-1:0] in_perms = 0;
  logic out_tag, out_sealed;
  logic [OTW-1:0] out_otype;
  logic [PW-1:0] out_perms;
  logic [AW-1:0] out_base, out_len, out_off;
  logic [2:0] out_cause;

  int checks = 0, errors = 0, cyc = 0;
  bit stall_en = 0, done = 0;
  item_t exp_q[$];
  string req_q[$];

  always #2.5 clk = ~clk;

  cap_derive_unit #(.AW(AW), .PW(PW), .OTW(OTW)) u0 (
    .clk, .rst, .in_valid, .in_ready, .in_op, .in_opnd, .in_tag, .in_sealed,
    .in_otype, .in_perms, .in_base, .in_len, .in_off, .out_valid, .out_ready,
    .out_tag, .out_sealed, .out_otype, .out_perms, .out_base, .out_len,
    .out_off, .out_cause
  );

  task automatic chk(bit ok, string rq, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // expected result computed from the requirement text
  function automatic item_t model(logic [2:0] op, logic [AW-1:0] opnd, item_t s);
    item_t r = s;
    r.cause = 3'd0;
    if (op > 3'd4) r.cause = 3'd4;
    else if (!s.tag) r.cause = 3'd1;
    else if (s.sealed) r.cause = 3'd2;
    else if (op == 3'd2 && (33'(s.off) + 33'(opnd) > 33'(s.len))) r.cause = 3'd3;
    if (r.cause != 0) begin
      r.tag = 1'b0;
      return r;
    end
    case (op)
      3'd0: r.off = opnd;
      3'd1: r.off = s.off + opnd;
      3'd2: begin r.base = s.base + s.off; r.len = opnd; r.off = '0; end
      3'd3: r.perms = s.perms & opnd[PW-1:0];
      default: begin r.sealed = 1'b1; r.otype = opnd[OTW-1:0]; end
    endcase
    return r;
  endfunction

  task automatic send(logic [2:0] op, logic [AW-1:0] opnd, logic tg, logic sl,
                      logic [PW-1:0] pm, logic [AW-1:0] bs, logic [AW-1:0] ln,
                      logic [AW-1:0] of, string rq);
    item_t s;
    bit acc;
    s = '{tag: tg, sealed: sl, otype: 24'h5A5A5A, perms: pm, base: bs, len: ln, off: of, cause: 3'd0};
    exp_q.push_back(model(op, opnd, s));
    req_q.push_back(rq);
    @(negedge clk);
    in_valid = 1; in_op = op; in_opnd = opnd; in_tag = tg; in_sealed = sl;
    in_otype = s.otype; in_perms = pm; in_base = bs; in_len = ln; in_off = of;
    do begin
      #2;
      acc = in_ready;
      @(negedge clk);
    end while (!acc);
    in_valid = 0;
  endtask

  // back-pressure pattern on the output side
  always @(negedge clk) begin
    cyc++;
    out_ready = stall_en ? ((cyc % 4) == 0) : 1'b1;
  end

  // monitor / scoreboard
  item_t held;
  bit held_v = 0;
  always @(negedge clk) begin
    #2;
    if (!rst) begin
      if (held_v) begin
        chk(out_valid && out_off == held.off && out_base == held.base &&
            out_cause == held.cause && out_tag == held.tag, "R10", "stall hold",
            {out_base, out_off}, {held.base, held.off});
        held_v = 0;
      end
      if (out_valid && !out_ready) begin
        chk(!in_ready, "R10", "in_ready under stall", in_ready, 0);
        held = '{out_tag, out_sealed, out_otype, out_perms, out_base, out_len, out_off, out_cause};
        held_v = 1;
      end
      if (out_valid && out_ready) begin
        item_t e, a;
        string rq;
        a = '{out_tag, out_sealed, out_otype, out_perms, out_base, out_len, out_off, out_cause};
        if (exp_q.size() == 0) chk(0, "R10", "unexpected result", a, 0);
        else begin
          e = exp_q.pop_front();
          rq = req_q.pop_front();
          chk(a == e, rq, "result", a, e);
        end
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    #2;
    chk(out_valid == 0, "R11", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1, "R11", "in_ready after reset", in_ready, 1);
    for (int pass = 0; pass < 2; pass++) begin
      stall_en = (pass == 1);
      send(3'd0, 32'h20,       1, 0, 8'hF5, 32'h1000, 32'h100, 32'h10, "R1");
      send(3'd0, 32'h500,      1, 0, 8'hF5, 32'h1000, 32'h100, 32'h10, "R1");
      send(3'd1, 32'h8,        1, 0, 8'hF5, 32'h1000, 32'h100, 32'h10, "R2");
      send(3'd1, 32'h20,       1, 0, 8'hF5, 32'h1000, 32'h100, 32'hFFFFFFF0, "R2");
      send(3'd2, 32'h80,       1, 0, 8'hF5, 32'h1000, 32'h100, 32'h10, "R3");
      send(3'd2, 32'h80,       1, 0, 8'hF5, 32'h1000, 32'h100, 32'h80, "R3");
      send(3'd2, 32'h81,       1, 0, 8'hF5, 32'h1000, 32'h100, 32'h80, "R3 R9");
      send(3'd2, 32'h0,        1, 0, 8'hF5, 32'h1000, 32'h100, 32'h200, "R3 R9");
      send(3'd3, 32'h3C,       1, 0, 8'hF5, 32'h1000, 32'h100, 32'h10, "R4");
      send(3'd3, 32'hFFFFFF00, 1, 0, 8'hF5, 32'h1000, 32'h100, 32'h10, "R4");
      send(3'd3, 32'hFF,       1, 0, 8'hF5, 32'h1000, 32'h100, 32'h10, "R4");
      send(3'd4, 32'h12ABCDEF, 1, 0, 8'hF5, 32'h1000, 32'h100, 32'h10, "R5");
      send(3'd0, 32'h40,       1, 1, 8'hF5, 32'h1000, 32'h100, 32'h10, "R6 R9");
      send(3'd4, 32'h77,       1, 1, 8'hF5, 32'h1000, 32'h100, 32'h10, "R6");
      send(3'd3, 32'h0,        0, 0, 8'hF5, 32'h1000, 32'h100, 32'h10, "R7");
      send(3'd2, 32'h10,       0, 1, 8'hF5, 32'h1000, 32'h100, 32'h10, "R7");
      send(3'd5, 32'h0,        1, 0, 8'hF5, 32'h1000, 32'h100, 32'h10, "R8");
      send(3'd7, 32'h0,        0, 1, 8'hF5, 32'h1000, 32'h100, 32'h10, "R8");
    end
    stall_en = 0;
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R10", "results outstanding", exp_q.size(), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule